// File: doc/BRIEF.md
# Edge-Selectable Serial Register Port

This block is a synchronous slave serial port. It gives a host read and write access to a bank of 8-bit registers. The host drives an active-low select, a serial clock and a data line. The port answers on a data output line. A strap input chooses which serial clock edge is active. Incoming bits are taken on the active edge. Outgoing bits change on the opposite edge, so the receiving side always sees a stable bit when it samples.

Every access is one frame. An 8-bit command comes first and carries the direction, a wire-mode flag, a reserved bit and a 5-bit register number. One 8-bit data byte follows, most significant bit first. In the 2-wire mode, read data is also driven back onto the host's data line, so a host with a single bidirectional data wire can use the port. The pads are asynchronous to the block clock. They pass through a two-stage synchronizer, and all outputs come from registers. Each output therefore trails the pins by a few block-clock cycles.

Top module: `ssp_port`

## Requirements
- R1: With `edge_sel`=1 the rising edge of `sclk` is active; with `edge_sel`=0 the falling edge is active. Input bits are captured only on the active edge.
- R2: The command byte is bit 7 = 1 for read and 0 for write, bit 6 = 1 for 2-wire, bit 5 reserved, and bits 4..0 the register number. A write stores its data byte, sent MSB first, at the 16th active edge of the frame.
- R3: In a read, the register's byte leaves on `sdo` MSB first. Each bit is updated after an inactive edge and is valid before the next active edge, starting with the inactive edge that follows the 8th active edge.
- R4: `sdo_oe` is 1 whenever `cs_n` is low and 0 whenever it is high, after at most 4 clock cycles of synchronizer and output delay. This holds in both wire modes.
- R5: In a 2-wire read, `sdi_oe` is 1 for the whole data byte and `sdi_out` carries the same bit as `sdo`. In a 3-wire access, `sdi_oe` stays 0.
- R6: While `cs_n` is high, `sdi_oe` is 0 whatever the last wire mode was.
- R7: While `cs_n` is high, `sclk` and `sdi_in` are ignored, and no register changes.
- R8: `rst` clears every register to zero and leaves `sdo`, `sdo_oe` and `sdi_oe` at 0.
- R9: Raising `cs_n` before the 16th active edge aborts the frame, and no register is written.
- R10: Active edges after the 16th in one frame are ignored. At most one write happens per frame.
- R11: A command with reserved bit 5 set is a no-op: it writes nothing, and a read of that kind drives only zeros and never enables `sdi_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial pins |
| rst | input | 1 | Synchronous active-high master reset |
| edge_sel | input | 1 | Strap: 1 = rising serial edge active, 0 = falling |
| cs_n | input | 1 | Active-low port select |
| sclk | input | 1 | Serial clock from the host |
| sdi_in | input | 1 | Value seen on the host data line |
| sdi_out | output | 1 | Read data driven back onto the host data line |
| sdi_oe | output | 1 | Drive enable for the host data line (2-wire read) |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Drive enable for the data output pad |

## Verification
The main function is exercised by six write-then-read pairs. Each pair writes with one clock polarity and reads back with the other, and the data bytes are all-ones, single-bit, alternating and nibble patterns. Because the data line changes at the same instant as the inactive edge, a port that samples on the wrong edge reads every bit shifted by one. This separates the correct polarity from the wrong one in both directions. The 3-wire and 2-wire reads are compared on both output lines and both drive enables, which separates wire-mode handling from plain read data. Directed frames then clock with the port deselected, cut frames short after 12 and 15 bits, run 24 bits long, and set the reserved bit. Each of these shows whether the register bank was touched when it must not be.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int CMD_BITS  = 8;
  localparam int ADDR_BITS = 5;

  typedef struct packed {
    logic                 rd;
    logic                 two_wire;
    logic                 rsvd;
    logic [ADDR_BITS-1:0] addr;
  } cmd_t;
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int           W       = 4,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= RST_VAL;
    else     stage[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[i] <= RST_VAL;
      else     stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/ssp_edge.sv
module ssp_edge (
  input  logic clk,
  input  logic rst,
  input  logic sclk_s,
  input  logic rise_act,
  output logic act,
  output logic inact
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= sclk_s;
  end

  logic rise, fall;
  assign rise  = sclk_s & ~prev;
  assign fall  = ~sclk_s & prev;
  assign act   = rise_act ? rise : fall;
  assign inact = rise_act ? fall : rise;
endmodule

// File: rtl/ssp_regfile.sv
module ssp_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 32,
  parameter int AW   = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] bank [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                                q <= '0;
      else if (wr_en && wr_addr == AW'(i))    q <= wr_data;
    end
    assign bank[i] = q;
  end

  if (NREG == (1 << AW)) begin : g_full
    assign rd_data = bank[rd_addr];
  end else begin : g_part
    assign rd_data = (int'(rd_addr) < NREG) ? bank[rd_addr] : '0;
  end
endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_s,
  input  logic                 sdi_s,
  input  logic                 act,
  input  logic                 inact,
  output logic                 wr_en,
  output logic [ADDR_BITS-1:0] addr,
  output logic [DW-1:0]        wr_data,
  input  logic [DW-1:0]        rd_data,
  output logic                 rd_phase,
  output logic                 two_wire,
  output logic                 out_bit
);
  localparam int FRAME = CMD_BITS + DW;
  localparam int SW    = (DW > CMD_BITS) ? DW : CMD_BITS;
  localparam int CW    = $clog2(FRAME + 1);

  logic [CW-1:0] cnt;
  logic [SW-1:0] sr_in;
  logic [DW-1:0] sr_out;
  cmd_t          cmd;
  cmd_t          next_cmd;
  logic [SW-1:0] next_sr;

  assign next_sr  = {sr_in[SW-2:0], sdi_s};
  assign next_cmd = cmd_t'(next_sr[CMD_BITS-1:0]);

  always_ff @(posedge clk) begin
    if (rst || cs_s) begin
      cnt      <= '0;
      rd_phase <= 1'b0;
      wr_en    <= 1'b0;
      if (rst) begin
        sr_in   <= '0;
        sr_out  <= '0;
        cmd     <= '0;
        wr_data <= '0;
      end
    end else begin
      wr_en <= 1'b0;
      if (act && cnt != CW'(FRAME)) begin
        sr_in <= next_sr;
        cnt   <= cnt + 1'b1;
        if (cnt == CW'(CMD_BITS - 1))
          cmd <= next_cmd;
        if (cnt == CW'(FRAME - 1) && !cmd.rd && !cmd.rsvd) begin
          wr_en   <= 1'b1;
          wr_data <= next_sr[DW-1:0];
        end
      end else if (inact) begin
        if (cnt == CW'(CMD_BITS) && cmd.rd && !cmd.rsvd) begin
          sr_out   <= rd_data;
          rd_phase <= 1'b1;
        end else if (rd_phase) begin
          if (cnt == CW'(FRAME)) rd_phase <= 1'b0;
          else                   sr_out   <= {sr_out[DW-2:0], 1'b0};
        end
      end
    end
  end

  assign addr     = cmd.addr;
  assign two_wire = cmd.two_wire;
  assign out_bit  = sr_out[DW-1];
endmodule

// File: rtl/ssp_port.sv
module ssp_port
  import ssp_pkg::*;
#(
  parameter int DW          = 8,
  parameter int NREG        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_sel,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi_in,
  output logic sdi_out,
  output logic sdi_oe,
  output logic sdo,
  output logic sdo_oe
);
  logic [3:0] pins_s;
  logic       rise_act, cs_s, sclk_s, sdi_s;
  logic       act, inact;

  ssp_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({edge_sel, cs_n, sclk, sdi_in}),
    .q   (pins_s)
  );
  assign {rise_act, cs_s, sclk_s, sdi_s} = pins_s;

  ssp_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .sclk_s   (sclk_s),
    .rise_act (rise_act),
    .act      (act),
    .inact    (inact)
  );

  logic                 wr_en;
  logic [ADDR_BITS-1:0] addr;
  logic [DW-1:0]        wr_data, rd_data;
  logic                 rd_phase, two_wire, out_bit;

  ssp_ctrl #(.DW(DW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cs_s     (cs_s),
    .sdi_s    (sdi_s),
    .act      (act),
    .inact    (inact),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .rd_phase (rd_phase),
    .two_wire (two_wire),
    .out_bit  (out_bit)
  );

  ssp_regfile #(.DW(DW), .NREG(NREG), .AW(ADDR_BITS)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (addr),
    .wr_data (wr_data),
    .rd_addr (addr),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo     <= 1'b0;
      sdo_oe  <= 1'b0;
      sdi_out <= 1'b0;
      sdi_oe  <= 1'b0;
    end else begin
      sdo     <= ~cs_s & rd_phase & out_bit;
      sdo_oe  <= ~cs_s;
      sdi_out <= ~cs_s & rd_phase & out_bit;
      sdi_oe  <= ~cs_s & rd_phase & two_wire;
    end
  end
endmodule

// File: rtl/ssp_port_chk.sv
module ssp_port_chk (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic sdo,
  input logic sdo_oe,
  input logic sdi_out,
  input logic sdi_oe,
  input logic wr_en
);
  // R5
  sdi_drive_needs_sdo_chk: assert property (@(posedge clk) disable iff (rst)
    sdi_oe |-> sdo_oe);

  // R5
  sdi_same_bit_chk: assert property (@(posedge clk) disable iff (rst)
    sdi_oe |-> (sdi_out == sdo));

  // R4
  deselect_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cs_n, 1) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_oe);

  // R6
  deselect_no_sdi_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cs_n, 1) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdi_oe);

  // R7
  write_when_selected_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !$past(cs_n, 3));

  // R10
  single_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!sdo && !sdo_oe && !sdi_oe));
endmodule

bind ssp_port ssp_port_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .cs_n    (cs_n),
  .sdo     (sdo),
  .sdo_oe  (sdo_oe),
  .sdi_out (sdi_out),
  .sdi_oe  (sdi_oe),
  .wr_en   (wr_en)
);

// File: tb/tb_ssp_port.sv
module tb_ssp_port;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic edge_sel = 1'b1;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi_in = 1'b0;
  logic sdi_out, sdi_oe, sdo, sdo_oe;

  always #2 clk = ~clk;

  ssp_port dut (
    .clk (clk), .rst (rst), .edge_sel (edge_sel), .cs_n (cs_n),
    .sclk (sclk), .sdi_in (sdi_in), .sdi_out (sdi_out), .sdi_oe (sdi_oe),
    .sdo (sdo), .sdo_oe (sdo_oe)
  );

  int checks = 0;
  int errors = 0;

  logic [7:0] q_sdo, q_sdi;
  int         n_sdi_oe, n_sdo_oe;

  // {edge_sel, two_wire, addr[4:0], data[7:0]}
  localparam logic [14:0] VEC [6] = '{
    {1'b1, 1'b0, 5'd0,  8'hA5},
    {1'b0, 1'b0, 5'd31, 8'h3C},
    {1'b1, 1'b1, 5'd7,  8'hFF},
    {1'b0, 1'b1, 5'd16, 8'h01},
    {1'b1, 1'b0, 5'd9,  8'h80},
    {1'b0, 1'b1, 5'd22, 8'h5A}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drives one frame of nbits; data line changes together with the inactive edge.
  task automatic xfer(input logic es, input logic [7:0] cmd, input logic [7:0] wd,
                      input int nbits, input logic sel);
    logic [23:0] f;
    f = {cmd, wd, 8'h3C};
    q_sdo = '0; q_sdi = '0; n_sdi_oe = 0; n_sdo_oe = 0;
    edge_sel = es;
    sclk = ~es;
    waitc(2 * H);
    cs_n = ~sel;
    waitc(H);
    for (int b = 0; b < nbits; b++) begin
      sdi_in = f[23-b];
      waitc(H);
      if (b >= 8 && b < 16) begin
        q_sdo[15-b] = sdo;
        q_sdi[15-b] = sdi_out;
        n_sdi_oe += int'(sdi_oe);
        n_sdo_oe += int'(sdo_oe);
      end
      sclk = es;
      waitc(H);
      sclk = ~es;
    end
    waitc(H);
    cs_n = 1'b1;
    waitc(H);
  endtask

  task automatic wr(input logic es, input logic [4:0] a, input logic [7:0] d);
    xfer(es, {3'b000, a}, d, 16, 1'b1);
  endtask

  task automatic rd(input logic es, input logic tw, input logic [4:0] a);
    xfer(es, {1'b1, tw, 1'b0, a}, 8'h00, 16, 1'b1);
  endtask

  initial begin
    waitc(200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    waitc(6);
    rst = 1'b0;
    waitc(2);
    // R8 reset state of outputs
    check("R8 sdo_oe", 32'(sdo_oe), 32'd0);
    check("R8 sdi_oe", 32'(sdi_oe), 32'd0);
    check("R8 sdo", 32'(sdo), 32'd0);

    // R1 R2 R3 R4 R5: write with one polarity, read back with the other
    foreach (VEC[i]) begin
      wr(VEC[i][14], VEC[i][12:8], VEC[i][7:0]);
      rd(~VEC[i][14], VEC[i][13], VEC[i][12:8]);
      check("R1 R2 R3 readback", 32'(q_sdo), 32'(VEC[i][7:0]));
      check("R4 sdo_oe during frame", 32'(n_sdo_oe), 32'd8);
      if (VEC[i][13]) begin
        check("R5 sdi_out copy", 32'(q_sdi), 32'(VEC[i][7:0]));
        check("R5 sdi_oe in 2-wire", 32'(n_sdi_oe), 32'd8);
      end else begin
        check("R5 sdi_oe in 3-wire", 32'(n_sdi_oe), 32'd0);
      end
      check("R4 sdo_oe after deselect", 32'(sdo_oe), 32'd0);
      check("R6 sdi_oe after deselect", 32'(sdi_oe), 32'd0);
    end

    // R7: clocking while deselected
    wr(1'b1, 5'd3, 8'h42);
    xfer(1'b1, {3'b000, 5'd3}, 8'h99, 16, 1'b0);
    check("R7 sdo_oe while deselected", 32'(sdo_oe), 32'd0);
    rd(1'b1, 1'b0, 5'd3);
    check("R7 register untouched", 32'(q_sdo), 32'h42);

    // R9: aborted frames
    xfer(1'b0, {3'b000, 5'd3}, 8'h11, 12, 1'b1);
    rd(1'b0, 1'b0, 5'd3);
    check("R9 abort after 12", 32'(q_sdo), 32'h42);
    xfer(1'b1, {3'b000, 5'd3}, 8'h11, 15, 1'b1);
    rd(1'b1, 1'b0, 5'd3);
    check("R9 abort after 15", 32'(q_sdo), 32'h42);

    // R10: 24-edge frame writes only the first data byte
    xfer(1'b1, {3'b000, 5'd5}, 8'h96, 24, 1'b1);
    rd(1'b0, 1'b0, 5'd5);
    check("R10 extra edges ignored", 32'(q_sdo), 32'h96);

    // R11: reserved bit set
    wr(1'b1, 5'd12, 8'h11);
    xfer(1'b1, {3'b001, 5'd12}, 8'h77, 16, 1'b1);
    rd(1'b1, 1'b0, 5'd12);
    check("R11 reserved write no-op", 32'(q_sdo), 32'h11);
    xfer(1'b0, {3'b111, 5'd12}, 8'h00, 16, 1'b1);
    check("R11 reserved read data", 32'(q_sdo), 32'h00);
    check("R11 reserved read sdi_oe", 32'(n_sdi_oe), 32'd0);

    // R8: master reset clears every register
    waitc(2);
    rst = 1'b1;
    waitc(3);
    rst = 1'b0;
    waitc(2);
    for (int a = 0; a < 32; a++) begin
      rd(a[0], 1'b0, 5'(a));
      check("R8 register cleared", 32'(q_sdo), 32'h00);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule